// File: doc/BRIEF.md
# Slave Clock Thirty-Second Impulse Driver

This block produces the stepping impulses for a chain of slave clock movements. Each movement advances one step per impulse. The block takes a one-cycle 1 Hz tick and a one-cycle minute-rollover pulse. In normal running it divides the tick first by ten and then by three, so it gives one impulse every thirty seconds. Each impulse is stretched to a fixed width by a non-retriggerable pulse stretcher before it leaves the block.

A sync input, while held, lets the minute-rollover pulse clear both divider stages, so impulses fall on the minute and the half minute. A two-bit mode input selects one of three modes:
- Normal: thirty-second impulses are passed on.
- Retard: impulses are held back so the slaves stop, for example to lose an hour. Entering retard gives one last forward impulse, which is useful for fine setting.
- Advance: every 1 Hz tick is sent out as an impulse.

Three indicators are provided. A running lamp and a retard lamp show the current mode, and an activity lamp flashes with every impulse delivered. The mode and sync inputs are assumed to be debounced and synchronous to `clk`.

Top module: `slave_impulse_drv`

## Requirements
- R1: A tick advances the divide-by-ten stage. Every tenth tick advances the divide-by-three stage. Both stages keep counting in every mode.
- R2: In normal mode (mode 2'b00, or the unused code 2'b11), an impulse starts in the clock cycle after every thirtieth tick, counted from reset or from the last re-phase.
- R3: While sync is high, a minute-rollover pulse clears both stages. The next impulse then follows the thirtieth tick after the pulse.
- R4: A minute-rollover pulse while sync is low has no effect on the impulse timing.
- R5: In retard mode (2'b01), no divided impulse and no tick reaches the output. The retard lamp is high and the running lamp is low. In the other modes the lamps are reversed.
- R6: A change into retard mode from any other mode gives exactly one impulse, starting in the next cycle. Staying in retard gives no more impulses. Leaving reset with retard already selected gives none.
- R7: In advance mode (2'b10), each tick starts an impulse in the following cycle, provided the stretcher is idle.
- R8: Each impulse stays high for exactly PULSE_W clock cycles.
- R9: A trigger that arrives while an impulse is still high is ignored. It does not lengthen the impulse.
- R10: The activity lamp is high in exactly the cycles in which the impulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 1 Hz tick |
| min_roll_i | input | 1 | One-cycle minute-rollover pulse |
| sync_i | input | 1 | Level; lets minute rollover clear the dividers |
| mode_i | input | 2 | 00 normal, 01 retard, 10 advance, 11 normal |
| impulse_o | output | 1 | Stretched impulse to the slave drive |
| run_led_o | output | 1 | Running indicator |
| retard_led_o | output | 1 | Retard indicator |
| activity_o | output | 1 | Flashes with each delivered impulse |

## Verification
The bench keeps the default divider ratios of ten and three, so a full thirty-tick cycle and the re-phase points are exercised at their real spacing. It builds the block with PULSE_W set to 4 and spaces ticks eight cycles apart. This makes the pulse width directly countable, and a second tick can be placed two cycles into a live impulse to exercise the ignored-retrigger case.

// File: rtl/slave_impulse_pkg.sv
package slave_impulse_pkg;
    typedef enum logic [1:0] {
        MODE_RUN    = 2'b00,
        MODE_RETARD = 2'b01,
        MODE_ADV    = 2'b10,
        MODE_SPARE  = 2'b11
    } drv_mode_e;
endpackage

// File: rtl/sid_mod_counter.sv
module sid_mod_counter #(
    parameter int MODULUS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic wrap_o
);
    localparam int CW = (MODULUS > 2) ? $clog2(MODULUS) : 1;
    localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

    typedef struct packed {
        logic [CW-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (clr_i) begin
            st_d.count = '0;
        end else if (inc_i) begin
            if (st_q.count == LAST) begin
                st_d.count = '0;
                wrap_o     = 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    wrap_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (st_q.count == LAST));

    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.count == '0));
endmodule

// File: rtl/sid_stretcher.sv
module sid_stretcher #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int WW = $clog2(PULSE_W + 1);
    localparam logic [WW-1:0] LOAD = WW'(PULSE_W);

    typedef struct packed {
        logic [WW-1:0] remain;
    } str_state_t;

    str_state_t st_d, st_q;
    logic busy;

    assign busy    = (st_q.remain != '0);
    assign pulse_o = busy;

    always_comb begin
        st_d = st_q;
        if (busy)        st_d.remain = st_q.remain - 1'b1;
        else if (trig_i) st_d.remain = LOAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig_i) |=> (st_q.remain != LOAD));

    // R8
    idle_trigger_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_i) |=> pulse_o);
endmodule

// File: rtl/slave_impulse_drv.sv
module slave_impulse_drv
    import slave_impulse_pkg::*;
#(
    parameter int TICKS_PER_STEP = 10,
    parameter int STEPS_PER_IMP  = 3,
    parameter int PULSE_W        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       min_roll_i,
    input  logic       sync_i,
    input  logic [1:0] mode_i,
    output logic       impulse_o,
    output logic       run_led_o,
    output logic       retard_led_o,
    output logic       activity_o
);
    typedef struct packed {
        logic in_retard;
    } top_state_t;

    top_state_t st_d, st_q;

    logic rephase, ten_wrap, imp30, trig, now_retard, now_adv;

    assign rephase    = sync_i && min_roll_i;
    assign now_retard = (mode_i == MODE_RETARD);
    assign now_adv    = (mode_i == MODE_ADV);

    sid_mod_counter #(.MODULUS(TICKS_PER_STEP)) u_ten (
        .clk(clk), .rst_n(rst_n), .clr_i(rephase),
        .inc_i(tick_i), .wrap_o(ten_wrap)
    );

    sid_mod_counter #(.MODULUS(STEPS_PER_IMP)) u_three (
        .clk(clk), .rst_n(rst_n), .clr_i(rephase),
        .inc_i(ten_wrap), .wrap_o(imp30)
    );

    always_comb begin
        st_d.in_retard = now_retard;
        if (now_retard)   trig = !st_q.in_retard;
        else if (now_adv) trig = tick_i;
        else              trig = imp30;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{in_retard: 1'b1};
        else        st_q <= st_d;
    end

    sid_stretcher #(.PULSE_W(PULSE_W)) u_stretch (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(impulse_o)
    );

    assign activity_o   = impulse_o;
    assign run_led_o    = !now_retard;
    assign retard_led_o = now_retard;

    // R5
    retard_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now_retard && $past(now_retard) && $past(now_retard, 2)) |-> !$rose(impulse_o));

    // R7
    advance_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now_adv && tick_i && !impulse_o) |=> impulse_o);

    // R6
    retard_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (now_retard && !st_q.in_retard && !impulse_o) |=> impulse_o);
endmodule

// File: tb/slave_impulse_drv_tb.sv
module slave_impulse_drv_tb;
    localparam int PW  = 4;
    localparam int GAP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, mroll = 1'b0, sync = 1'b0;
    logic [1:0] mode = 2'b00;
    logic imp, run_led, ret_led, act;

    always #2.5 clk = ~clk;

    slave_impulse_drv #(.PULSE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .min_roll_i(mroll),
        .sync_i(sync), .mode_i(mode), .impulse_o(imp),
        .run_led_o(run_led), .retard_led_o(ret_led), .activity_o(act)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t exp_q[$];
    int checks = 0, fails = 0;
    logic armed = 1'b0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    always @(posedge clk) armed <= tick;

    // monitor: compares the cycle after each tick
    always @(negedge clk) begin
        if (armed && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(imp == it.exp, it.tag, int'(imp), int'(it.exp));
            check(act == imp, "R10", int'(act), int'(imp));
        end
    end

    task automatic do_tick(input logic e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (GAP - 1) @(negedge clk);
    endtask

    task automatic run_ticks(input int n, input logic last_exp, input string tag);
        for (int i = 1; i <= n; i++) do_tick((i == n) ? last_exp : 1'b0, tag);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(imp == 1'b0, "R8 reset", int'(imp), 0);
        check(run_led == 1'b1 && ret_led == 1'b0, "R5 reset", int'(ret_led), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: two full thirty-tick cycles from reset
        run_ticks(30, 1'b1, "R2");
        run_ticks(30, 1'b1, "R2");

        // R3: re-phase at minute rollover while sync held
        run_ticks(7, 1'b0, "R3");
        sync = 1'b1; mroll = 1'b1;
        @(negedge clk);
        mroll = 1'b0; sync = 1'b0;
        repeat (GAP) @(negedge clk);
        run_ticks(30, 1'b1, "R3");

        // R4: rollover without sync ignored
        run_ticks(10, 1'b0, "R4");
        mroll = 1'b1;
        @(negedge clk);
        mroll = 1'b0;
        repeat (GAP) @(negedge clk);
        run_ticks(20, 1'b1, "R4");

        // R6: entry into retard gives one impulse
        mode = 2'b01;
        @(negedge clk);
        check(imp == 1'b1, "R6 entry", int'(imp), 1);
        check(ret_led == 1'b1 && run_led == 1'b0, "R5 lamps", int'(run_led), 0);
        repeat (PW + 2) @(negedge clk);
        check(imp == 1'b0, "R6 single", int'(imp), 0);
        // R5: thirty ticks in retard, all blocked
        run_ticks(30, 1'b0, "R5");

        // R7: advance, every tick pulses
        mode = 2'b10;
        @(negedge clk);
        check(run_led == 1'b1 && ret_led == 1'b0, "R5 lamps adv", int'(ret_led), 0);
        for (int i = 0; i < 5; i++) do_tick(1'b1, "R7");

        // R1: dividers kept counting (5 ticks since last wrap) -> 25 more
        mode = 2'b11;
        @(negedge clk);
        run_ticks(25, 1'b1, "R1");

        // R8 width and R9 retrigger in advance mode
        mode = 2'b10;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        exp_q.delete();
        for (int c = 1; c <= PW + 1; c++) begin
            if (c == 2) tick = 1'b1;
            if (c == 3) tick = 1'b0;
            if (c <= PW) check(imp == 1'b1, "R8 high", int'(imp), 1);
            else         check(imp == 1'b0, "R9 no extend", int'(imp), 0);
            @(negedge clk);
        end
        exp_q.delete();
        repeat (GAP) @(negedge clk);

        // R6: reset while in retard gives no impulse
        mode = 2'b01;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(imp == 1'b0, "R6 reset retard", int'(imp), 0);
        end

        finish_up();
    end
endmodule